// File: doc/BRIEF.md
# Inbound PCI Memory Window Translator

This block sits between a PCI target's protocol engine and the local bus. For every incoming PCI memory address it decides whether the address lies inside one of two inbound windows. If it does, the block produces the local bus address that the access maps to. If it does not, the block tells the protocol engine to leave the cycle unclaimed.

Each window has three registers: a PCI-side base, a local-side base, and a size register that carries an enable bit and a size mask. Window sizes are powers of two from 1 MB to 512 MB. Only the address bits above the window size are compared. The translated address takes its upper bits from the local base and its lower bits from the incoming address.

When neither window is enabled, the block forwards every memory address unchanged. This is pass-through mode, and it is the state after reset. A simple write port loads the six registers. Results are registered and appear one cycle after a request.

Top module: `atw_translator`

## Requirements
- R1: After reset, `rsp_valid` is 0. Both enable bits and all base registers are 0, so the first memory request is handled in pass-through mode.
- R2: `rsp_valid` is 1 exactly in the cycle after a cycle with `req_valid` high. Whenever `rsp_valid` is 0, the outputs `rsp_hit`, `rsp_decline`, `rsp_pass`, `rsp_win` and `rsp_addr` are all 0.
- R3: A request hits an enabled window only when every address bit at or above the window's offset width equals the corresponding bit of that window's PCI base.
- R4: On a window hit, `rsp_addr` takes its bits at or above the offset width from the local base and its bits below from the request address.
- R5: Size register layout: bit 0 is the enable bit, and bits 28:20 are mask bits. The offset width is 20 plus the number of consecutive mask ones counted upward from bit 20, which gives 1 MB to 512 MB. A window whose enable bit is 0 never hits.
- R6: A mask bit that lies above the first zero mask bit has no effect on the window size.
- R7: When both windows hit, window 0 is reported (`rsp_win` = 0).
- R8: When at least one window is enabled and a memory request hits no enabled window, `rsp_decline` = 1, `rsp_hit` = 0 and `rsp_addr` = 0.
- R9: When both enable bits are 0, a memory request gives `rsp_hit` = 1, `rsp_pass` = 1, `rsp_win` = 0 and `rsp_addr` equal to the request address.
- R10: Only the memory command codes 4'b0110, 4'b0111, 4'b1100, 4'b1110 and 4'b1111 can hit, and all five translate the same way. Any other code is declined, in pass-through mode as well.
- R11: PCI and local base bits below the offset width affect neither the comparison nor `rsp_addr`.
- R12: A write with `cfg_we` = 1 updates one register from the next cycle on. The register is chosen by `cfg_sel[0]` (window) and `cfg_sel[2:1]` (0 = PCI base, 1 = local base, 2 = size).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: {kind[1:0], window} |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Address request valid |
| req_addr | input | 32 | Incoming PCI address |
| req_cmd | input | 4 | PCI command code |
| rsp_valid | output | 1 | Result valid, one cycle after request |
| rsp_hit | output | 1 | Address claimed |
| rsp_decline | output | 1 | Do not claim the cycle |
| rsp_pass | output | 1 | Claimed in pass-through mode |
| rsp_win | output | 1 | Index of the hit window |
| rsp_addr | output | 32 | Local bus address |

## Verification
The bench sweeps every legal size of each window. For each size it probes the first and last byte of the window and the bytes just outside it on either side, and it writes the bases with junk in their low bits. A design that compares the wrong number of bits, or lets junk base bits through, fails at these edges. Separate cases cover overlapping windows (a wrong priority reports window 1) and a non-contiguous mask (a design that uses the raw mask claims a larger window). Further cases cover non-memory commands in both modes and the return to pass-through once both enables are cleared.

// File: rtl/atw_pkg.sv
// Package atw_pkg
// Holds the shared constants, types and helpers of the inbound window
// translator. It assumes a 32-bit PCI address space and two windows.
package atw_pkg;
    localparam int ADDR_W    = 32;
    localparam int OFS_LSB   = 20;   // smallest window: 1 MB
    localparam int MASK_W    = 9;    // mask bits 28:20 give up to 512 MB
    localparam int NUM_WIN   = 2;
    localparam int WIN_IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
    localparam int KIND_W    = 2;
    localparam int SEL_W     = WIN_IDX_W + KIND_W;
    localparam int CMD_W     = 4;
    localparam int SZ_EN_BIT = 0;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [KIND_W-1:0] {
        KIND_PBASE = 2'd0,
        KIND_LBASE = 2'd1,
        KIND_SIZE  = 2'd2
    } reg_kind_e;

    // Decoded view of one window, as seen by the match logic.
    typedef struct packed {
        logic  en;
        addr_t pbase;
        addr_t lbase;
        addr_t keep;   // ones on the offset bits
    } win_cfg_t;

    // Tells whether a PCI command is one of the memory read or write codes.
    function automatic logic is_mem_cmd(input logic [CMD_W-1:0] cmd);
        return (cmd == 4'b0110) || (cmd == 4'b0111) || (cmd == 4'b1100) ||
               (cmd == 4'b1110) || (cmd == 4'b1111);
    endfunction
endpackage

// File: rtl/atw_cfg_regs.sv
// Module atw_cfg_regs
// Holds the software-written base and size registers of each window and
// turns the raw size mask into a contiguous offset mask. Mask bits above the
// first zero are dropped. It assumes single-cycle writes with no read-back.
module atw_cfg_regs
    import atw_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [SEL_W-1:0]              cfg_sel,
    input  logic [ADDR_W-1:0]             cfg_wdata,
    output win_cfg_t [NUM_WIN-1:0]        cfg_o
);
    logic [WIN_IDX_W-1:0] sel_win;
    logic [KIND_W-1:0]    sel_kind;

    assign sel_win  = cfg_sel[WIN_IDX_W-1:0];
    assign sel_kind = cfg_sel[SEL_W-1:WIN_IDX_W];

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        logic [ADDR_W-1:0] pbase_q;
        logic [ADDR_W-1:0] lbase_q;
        logic [MASK_W-1:0] mask_q;
        logic              en_q;
        logic [MASK_W-1:0] eff_mask;
        logic              wr_this;

        assign wr_this = cfg_we && (sel_win == WIN_IDX_W'(w));

        // Load the selected register of this window.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pbase_q <= '0;
                lbase_q <= '0;
                mask_q  <= '0;
                en_q    <= 1'b0;
            end else if (wr_this) begin
                case (sel_kind)
                    KIND_PBASE: pbase_q <= cfg_wdata;
                    KIND_LBASE: lbase_q <= cfg_wdata;
                    KIND_SIZE: begin
                        mask_q <= cfg_wdata[OFS_LSB +: MASK_W];
                        en_q   <= cfg_wdata[SZ_EN_BIT];
                    end
                    default: ;
                endcase
            end
        end

        // Keep only the run of ones that starts at the lowest mask bit.
        always_comb begin
            logic run;
            run = 1'b1;
            for (int i = 0; i < MASK_W; i++) begin
                run         = run & mask_q[i];
                eff_mask[i] = run;
            end
        end

        assign cfg_o[w] = '{en:    en_q,
                            pbase: pbase_q,
                            lbase: lbase_q,
                            keep:  ADDR_W'({eff_mask, {OFS_LSB{1'b1}}})};

        // R6
        mask_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((eff_mask & (eff_mask + 1'b1)) == '0));

        // R1
        reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(!rst_n) |-> (!en_q && pbase_q == '0 && lbase_q == '0));
    end
endmodule

// File: rtl/atw_win_match.sv
// Module atw_win_match
// Compares one request address against one window and forms the translated
// address. It assumes the keep mask is contiguous from bit 0.
module atw_win_match
    import atw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  win_cfg_t          cfg_i,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              hit_o,
    output logic [ADDR_W-1:0] xlat_o
);
    logic [ADDR_W-1:0] diff;

    // Bits above the window offset must equal the PCI base.
    always_comb begin
        diff  = (req_addr ^ cfg_i.pbase) & ~cfg_i.keep;
        hit_o = cfg_i.en && (diff == '0);
    end

    // Upper bits from the local base, offset bits from the request.
    always_comb begin
        xlat_o = (cfg_i.lbase & ~cfg_i.keep) | (req_addr & cfg_i.keep);
    end

    // R4
    offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (((xlat_o ^ req_addr) & cfg_i.keep) == '0));
endmodule

// File: rtl/atw_resolve.sv
// Module atw_resolve
// Picks the result from the per-window matches: pass-through when no window
// is enabled, lowest-index window otherwise, and a command filter. The
// outputs are registered. It assumes one request per cycle with no stall.
module atw_resolve
    import atw_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [CMD_W-1:0]              req_cmd,
    input  logic [NUM_WIN-1:0]            en_vec,
    input  logic [NUM_WIN-1:0]            hit_vec,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0] xlat_vec,
    output logic                          rsp_valid,
    output logic                          rsp_hit,
    output logic                          rsp_decline,
    output logic                          rsp_pass,
    output logic [WIN_IDX_W-1:0]          rsp_win,
    output logic [ADDR_W-1:0]             rsp_addr
);
    logic                 nxt_hit;
    logic                 nxt_pass;
    logic [WIN_IDX_W-1:0] nxt_win;
    logic [ADDR_W-1:0]    nxt_addr;
    logic                 mem_cmd;
    logic                 any_en;

    assign mem_cmd = is_mem_cmd(req_cmd);
    assign any_en  = |en_vec;

    // Choose pass-through or the lowest-index hitting window.
    always_comb begin
        nxt_hit  = 1'b0;
        nxt_pass = 1'b0;
        nxt_win  = '0;
        nxt_addr = '0;
        if (mem_cmd) begin
            if (!any_en) begin
                nxt_hit  = 1'b1;
                nxt_pass = 1'b1;
                nxt_addr = req_addr;
            end else begin
                for (int w = NUM_WIN - 1; w >= 0; w--) begin
                    if (hit_vec[w]) begin
                        nxt_hit  = 1'b1;
                        nxt_win  = WIN_IDX_W'(w);
                        nxt_addr = xlat_vec[w];
                    end
                end
            end
        end
    end

    // Register the result; all outputs are zero when no request was seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_hit     <= 1'b0;
            rsp_decline <= 1'b0;
            rsp_pass    <= 1'b0;
            rsp_win     <= '0;
            rsp_addr    <= '0;
        end else begin
            rsp_valid   <= req_valid;
            rsp_hit     <= req_valid && nxt_hit;
            rsp_decline <= req_valid && !nxt_hit;
            rsp_pass    <= req_valid && nxt_pass;
            rsp_win     <= req_valid ? nxt_win : '0;
            rsp_addr    <= req_valid ? nxt_addr : '0;
        end
    end

    // R2
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && !rsp_decline && !rsp_pass && rsp_addr == '0));

    // R9
    pass_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_pass |-> (rsp_hit && rsp_addr == $past(req_addr)));

    // R7
    win_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mem_cmd && any_en && hit_vec[0]) |=> (rsp_hit && rsp_win == '0));
endmodule

// File: rtl/atw_translator.sv
// Module atw_translator
// Top level of the inbound PCI memory window translator. It connects the
// register file, one match unit per window and the result stage. It assumes
// the protocol engine presents one address per cycle and reads the result
// one cycle later.
module atw_translator
    import atw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    input  logic        req_valid,
    input  logic [31:0] req_addr,
    input  logic [3:0]  req_cmd,
    output logic        rsp_valid,
    output logic        rsp_hit,
    output logic        rsp_decline,
    output logic        rsp_pass,
    output logic        rsp_win,
    output logic [31:0] rsp_addr
);
    win_cfg_t [NUM_WIN-1:0]         win_cfg;
    logic [NUM_WIN-1:0]             en_vec;
    logic [NUM_WIN-1:0]             hit_vec;
    logic [NUM_WIN-1:0][ADDR_W-1:0] xlat_vec;

    atw_cfg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_o     (win_cfg)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
        assign en_vec[w] = win_cfg[w].en;

        atw_win_match u_match (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_i    (win_cfg[w]),
            .req_addr (req_addr),
            .hit_o    (hit_vec[w]),
            .xlat_o   (xlat_vec[w])
        );
    end

    atw_resolve u_resolve (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_cmd     (req_cmd),
        .en_vec      (en_vec),
        .hit_vec     (hit_vec),
        .xlat_vec    (xlat_vec),
        .rsp_valid   (rsp_valid),
        .rsp_hit     (rsp_hit),
        .rsp_decline (rsp_decline),
        .rsp_pass    (rsp_pass),
        .rsp_win     (rsp_win),
        .rsp_addr    (rsp_addr)
    );
endmodule

// File: tb/atw_translator_tb.sv
`timescale 1ns/1ps
module atw_translator_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_cmd = '0;
    logic        rsp_valid, rsp_hit, rsp_decline, rsp_pass, rsp_win;
    logic [31:0] rsp_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_pb [2];
    logic [31:0] m_lb [2];
    logic [31:0] m_sz [2];

    always #4 clk = ~clk;

    atw_translator dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
        .req_cmd(req_cmd), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_decline(rsp_decline), .rsp_pass(rsp_pass), .rsp_win(rsp_win),
        .rsp_addr(rsp_addr)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // R12: register select {kind, window}
    task automatic wr(input int kind, input int w, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = {kind[1:0], w[0]}; cfg_wdata = d;
        if (kind == 0) m_pb[w] = d;
        if (kind == 1) m_lb[w] = d;
        if (kind == 2) m_sz[w] = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic int ofs_width(input logic [31:0] sz);
        int n = 0;
        while (n < 9 && sz[20 + n]) n++;
        return 20 + n;
    endfunction

    // Drive one request and compare every output against the model.
    task automatic req(input string tag, input logic [31:0] a, input logic [3:0] c);
        logic mem, e_hit, e_pass, e_win;
        logic [31:0] e_addr;
        logic [63:0] lo;
        mem = (c == 4'b0110) || (c == 4'b0111) || (c == 4'b1100) ||
              (c == 4'b1110) || (c == 4'b1111);
        e_hit = 0; e_pass = 0; e_win = 0; e_addr = 0;
        if (mem && !m_sz[0][0] && !m_sz[1][0]) begin
            e_hit = 1; e_pass = 1; e_addr = a;
        end else if (mem) begin
            for (int w = 1; w >= 0; w--) begin
                int ow = ofs_width(m_sz[w]);
                if (m_sz[w][0] && (({32'd0, a} >> ow) == ({32'd0, m_pb[w]} >> ow))) begin
                    lo = (64'd1 << ow) - 1;
                    e_hit = 1; e_win = w[0];
                    e_addr = (m_lb[w] & ~lo[31:0]) | (a & lo[31:0]);
                end
            end
        end
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_cmd = c;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R2 valid"}, 32'(rsp_valid), 32'd1);
        chk({tag, " hit"}, 32'(rsp_hit), 32'(e_hit));
        chk({tag, " R8 decline"}, 32'(rsp_decline), 32'(!e_hit));
        chk({tag, " pass"}, 32'(rsp_pass), 32'(e_pass));
        chk({tag, " win"}, 32'(rsp_win), 32'(e_win));
        chk({tag, " addr"}, rsp_addr, e_addr);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] cmds [5] = '{4'b0110, 4'b0111, 4'b1100, 4'b1110, 4'b1111};
        for (int w = 0; w < 2; w++) begin m_pb[w] = 0; m_lb[w] = 0; m_sz[w] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 reset valid", 32'(rsp_valid), 32'd0);
        chk("R2 reset idle hit", 32'(rsp_hit), 32'd0);
        req("R1 R9 first", 32'h8765_4321, 4'b0110);
        for (int i = 0; i < 5; i++) req("R9 pass", $urandom, cmds[i]);
        req("R10 pass io", 32'h1234_5678, 4'b0010);
        req("R10 pass cfg", 32'h0000_0010, 4'b1010);
        @(negedge clk);
        chk("R2 idle valid", 32'(rsp_valid), 32'd0);
        chk("R2 idle addr", rsp_addr, 32'd0);

        // R3 R4 R5 R11 R12: sweep every size of each window alone.
        for (int w = 0; w < 2; w++) begin
            for (int k = 0; k < 10; k++) begin
                logic [31:0] sz, pb, base;
                logic [63:0] span;
                sz = 32'h1 | ((32'(1 << k) - 1) << 20);
                if (k == 9) sz = 32'h1 | (32'h1FF << 20);
                span = 64'd1 << ofs_width(sz);
                pb = $urandom;
                wr(2, 1 - w, 32'h0);
                wr(0, 1 - w, 32'h0);
                wr(0, w, pb);
                wr(1, w, $urandom);
                wr(2, w, sz | 32'hC000_0F00);
                base = pb & ~(span[31:0] - 1);
                req("R3 R11 low edge", base, cmds[k % 5]);
                req("R3 R4 high edge", base + span[31:0] - 1, cmds[(k + 1) % 5]);
                req("R3 R8 above", base + span[31:0], 4'b0110);
                req("R3 R8 below", base - 1, 4'b0111);
                req("R4 R10 inside", base | ($urandom & (span[31:0] - 1)), cmds[(k + 2) % 5]);
                req("R10 io inside", base, 4'b0011);
            end
        end

        // R5: disabled window never hits even on a matching address.
        wr(0, 0, 32'h4000_0000); wr(2, 0, 32'h0);
        wr(0, 1, 32'h1000_0000); wr(2, 1, 32'h1 | (32'h3 << 20));
        req("R5 R8 disabled match", 32'h4000_1234, 4'b0110);
        req("R5 enabled", 32'h1023_4567, 4'b0110);

        // R7: overlapping windows.
        wr(0, 0, 32'h2000_0000); wr(1, 0, 32'hA000_0000); wr(2, 0, 32'h1);
        wr(0, 1, 32'h2000_0000); wr(1, 1, 32'hB000_0000); wr(2, 1, 32'h1 | (32'hF << 20));
        req("R7 both", 32'h2000_0ABC, 4'b0111);
        chk("R7 window zero", 32'(rsp_win), 32'd0);
        req("R7 only one", 32'h2050_0ABC, 4'b1100);
        chk("R7 window one", 32'(rsp_win), 32'd1);

        // R6: mask bits 20 and 22 set; effective size 2 MB.
        wr(2, 1, 32'h0);
        wr(0, 0, 32'h3000_0000); wr(1, 0, 32'h5000_0000);
        wr(2, 0, 32'h1 | (32'h5 << 20));
        req("R6 inside", 32'h301F_FFFF, 4'b0110);
        req("R6 above run", 32'h3040_0000, 4'b0110);
        chk("R6 declined", 32'(rsp_decline), 32'd1);

        // R9: clearing both enables returns to pass-through.
        wr(2, 0, 32'h0);
        req("R9 back to pass", 32'h3040_0000, 4'b1110);
        chk("R9 pass flag", 32'(rsp_pass), 32'd1);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule